// File: doc/BRIEF.md
# Bus Arbitration and Selection Sequencer

This block carries a parallel SCSI node from a select command through arbitration, selection or reselection, and the handover into a connected mode. On a start pulse carrying a valid command it drives its own ID bit and BSY, waits out the arbitration interval, and then looks at the data lines. The highest-numbered set bit wins. A winner raises SEL, lets the bus settle, puts its own and the destination ID bits on the data lines, and then lets go of BSY. On a select-with-attention command it raises ATN at the same moment.

A target answers by pulling BSY. The sequencer then waits a two-cycle deskew, releases SEL and the data lines, and enters initiator mode. For a reselect command it instead drives BSY itself and enters target mode. If no answer comes, a selection timeout of 8192 cycles per unit of the programmed value runs. When it expires, the data lines are freed and an abort window follows. A BSY seen at any point in that time still completes the connection. Otherwise every line is released and a disconnect interrupt is raised. In initiator mode, losing BSY ends the connection and raises the same interrupt. A synchronous soft reset returns the block to idle with every line released.

Top module: `scsiSelSeq`

## Requirements
- R1: When the arbitration interval ends, the winner is the highest-numbered set bit on the data lines. If that bit is not the own ID, SEL, BSY, ATN and the data lines are released on the same edge, `arbLost` is set, and the block goes idle.
- R2: A winner raises SEL and keeps the data lines unchanged for exactly SETTLE_CYCLES cycles after SEL rises.
- R3: The data lines then carry the own ID bit ORed with the destination ID bit for exactly 4 cycles before BSY is released.
- R4: On the edge that releases BSY, ATN is driven high when the command code (bit 7 masked off) is 0x42 or 0x43, and low for 0x41 or 0x44.
- R5: If the target raises BSY, a 2-cycle deskew follows. The connected mode appears 3 samples after a BSY that arrives during the wait. At that point SEL and the data lines are released. Code 0x44 enters `targetMode` with own BSY driven from the start of the deskew; any other code enters `initMode`. The two modes are never active together.
- R6: With no BSY answer, the data lines are released exactly RELEASE_CYCLES + 8192 × `selTimeout` cycles after BSY was released (a value of 0 counts as 1). A BSY that arrives before then leads straight to the deskew.
- R7: After the timeout, an abort window of ABORT_CYCLES runs. A BSY present at its end still completes the connection. Otherwise all lines are released and `discIrq` rises exactly ABORT_CYCLES cycles after the data lines were freed.
- R8: In initiator mode, BSY going low leaves initiator mode and sets `discIrq` on the next edge.
- R9: Bit 7 of the command code has no effect. A start carrying any code other than 0x41–0x44 (after masking) drives no line.
- R10: A soft reset releases all lines and clears both modes and both flags on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| softRst | input | 1 | Synchronous soft reset |
| startCmd | input | 1 | One-cycle start strobe, accepted when idle |
| cmdCode | input | 8 | Command code; bit 7 ignored |
| ownId | input | ID_W | This node's bus ID |
| destId | input | ID_W | Destination ID, latched at start |
| selTimeout | input | TO_W | Selection timeout in units of 8192 cycles |
| busDataIn | input | BUS_W | Observed data lines (wired OR) |
| bsyIn | input | 1 | Observed BSY line (wired OR) |
| dataOut | output | BUS_W | Data driven onto the bus |
| dataOe | output | 1 | Data drive enable |
| selOut | output | 1 | SEL drive |
| bsyOut | output | 1 | BSY drive |
| atnOut | output | 1 | ATN drive |
| initMode | output | 1 | Connected as initiator |
| targetMode | output | 1 | Connected as target |
| discIrq | output | 1 | Disconnect interrupt flag |
| arbLost | output | 1 | Arbitration lost flag |

## Verification
The checker watches properties that can be judged at any edge. It confirms that a lost arbitration or a disconnect leaves every line released, that the own ID bit stays on the bus while SEL and data are driven, that the two modes never overlap, and that entering a mode frees SEL and the data lines. It also checks that a BSY drop in initiator mode raises the interrupt and that a soft reset clears everything. Only the bench scenarios can show the interval lengths (settle, the 4-cycle destination phase, the timeout and abort counts, the deskew latency), the winner choice for given competitor bits, the ATN and mode choice per command, and the rescue of a selection by a late BSY.

// File: rtl/scsiSelPkg.sv
package scsiSelPkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ARB, ST_SETTLE, ST_DEST, ST_RELBSY,
    ST_DESKEW, ST_SELWAIT, ST_ABORT, ST_CONN
  } selState_e;

  typedef enum logic [2:0] {
    TM_ARB, TM_SETTLE, TM_DEST, TM_RELEASE, TM_DESKEW, TM_SELTO, TM_ABORT
  } timerSel_e;

  typedef struct packed {
    logic      loadTimer;
    timerSel_e timerSel;
    logic      latchDest;
    logic      driveOwn;
    logic      driveBoth;
    logic      releaseData;
    logic      setSel;
    logic      clrSel;
    logic      setBsy;
    logic      clrBsy;
    logic      setAtn;
    logic      atnVal;
    logic      releaseAll;
  } ctrlStrobe_t;

  localparam logic [6:0] CMD_SELECT          = 7'h41;
  localparam logic [6:0] CMD_SELECT_ATN      = 7'h42;
  localparam logic [6:0] CMD_SELECT_ATN_STOP = 7'h43;
  localparam logic [6:0] CMD_RESELECT        = 7'h44;

  localparam int DEST_CYCLES   = 4;
  localparam int DESKEW_CYCLES = 2;
  localparam int TIMEOUT_UNIT_LOG2 = 13;

endpackage

// File: rtl/scsiSelDatapath.sv
module scsiSelDatapath
  import scsiSelPkg::*;
#(
  parameter int ID_W           = 3,
  parameter int TO_W           = 8,
  parameter int ARB_CYCLES     = 24,
  parameter int SETTLE_CYCLES  = 6,
  parameter int RELEASE_CYCLES = 2,
  parameter int ABORT_CYCLES   = 100,
  localparam int BUS_W         = 1 << ID_W,
  localparam int CNT_W         = TO_W + TIMEOUT_UNIT_LOG2
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      stb,
  input  logic [ID_W-1:0]  ownId,
  input  logic [ID_W-1:0]  destId,
  input  logic [TO_W-1:0]  selTimeout,
  input  logic [BUS_W-1:0] busDataIn,
  output logic             timerDone,
  output logic             arbWon,
  output logic [BUS_W-1:0] dataOut,
  output logic             dataOe,
  output logic             selOut,
  output logic             atnOut,
  output logic             bsyOut
);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;
  logic [TO_W-1:0]  toEff;
  logic [ID_W-1:0]  destQ;
  logic [ID_W-1:0]  winIdx;
  logic             anySet;

  assign toEff = (selTimeout == '0) ? TO_W'(1) : selTimeout;

  always_comb begin
    case (stb.timerSel)
      TM_ARB:     loadVal = CNT_W'(ARB_CYCLES);
      TM_SETTLE:  loadVal = CNT_W'(SETTLE_CYCLES);
      TM_RELEASE: loadVal = CNT_W'(RELEASE_CYCLES);
      TM_DESKEW:  loadVal = CNT_W'(DESKEW_CYCLES);
      TM_SELTO:   loadVal = {toEff, {TIMEOUT_UNIT_LOG2{1'b0}}};
      TM_ABORT:   loadVal = CNT_W'(ABORT_CYCLES);
      default:    loadVal = CNT_W'(DEST_CYCLES);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (stb.loadTimer) cnt <= loadVal - CNT_W'(1);
    else if (cnt != '0)     cnt <= cnt - CNT_W'(1);
  end

  assign timerDone = (cnt == '0);

  // highest set data line wins arbitration
  always_comb begin
    winIdx = '0;
    anySet = 1'b0;
    for (int i = 0; i < BUS_W; i++) begin
      if (busDataIn[i]) begin
        winIdx = ID_W'(i);
        anySet = 1'b1;
      end
    end
  end

  assign arbWon = anySet && (winIdx == ownId);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      destQ   <= '0;
      dataOut <= '0;
      dataOe  <= 1'b0;
      selOut  <= 1'b0;
      atnOut  <= 1'b0;
      bsyOut  <= 1'b0;
    end else if (stb.releaseAll) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
      selOut  <= 1'b0;
      atnOut  <= 1'b0;
      bsyOut  <= 1'b0;
    end else begin
      if (stb.latchDest) destQ <= destId;
      if (stb.driveOwn) begin
        dataOut <= BUS_W'(1) << ownId;
        dataOe  <= 1'b1;
      end else if (stb.driveBoth) begin
        dataOut <= (BUS_W'(1) << ownId) | (BUS_W'(1) << destQ);
        dataOe  <= 1'b1;
      end else if (stb.releaseData) begin
        dataOut <= '0;
        dataOe  <= 1'b0;
      end
      if (stb.setSel)      selOut <= 1'b1;
      else if (stb.clrSel) selOut <= 1'b0;
      if (stb.setBsy)      bsyOut <= 1'b1;
      else if (stb.clrBsy) bsyOut <= 1'b0;
      if (stb.setAtn)      atnOut <= stb.atnVal;
    end
  end

endmodule

// File: rtl/scsiSelCtrl.sv
module scsiSelCtrl
  import scsiSelPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        startCmd,
  input  logic [7:0]  cmdCode,
  input  logic        timerDone,
  input  logic        arbWon,
  input  logic        bsyIn,
  output ctrlStrobe_t stb,
  output logic        initMode,
  output logic        targetMode,
  output logic        discIrq,
  output logic        arbLost
);

  selState_e state, nxt;
  logic [6:0] cmdLow;
  logic validCmd;
  logic reselQ, atnQ;
  logic latchCmd, clrFlags, setDisc, setLost, dropMode, enterInit, enterTgt, goDeskew;

  assign cmdLow   = 7'(cmdCode & 8'h7F);
  assign validCmd = (cmdLow == CMD_SELECT) || (cmdLow == CMD_SELECT_ATN) ||
                    (cmdLow == CMD_SELECT_ATN_STOP) || (cmdLow == CMD_RESELECT);

  always_comb begin
    nxt = state;
    stb = '0;
    stb.timerSel = TM_DEST;
    {latchCmd, clrFlags, setDisc, setLost, dropMode, enterInit, enterTgt, goDeskew} = '0;

    case (state)
      ST_IDLE: if (startCmd && validCmd) begin
        latchCmd = 1'b1;
        clrFlags = 1'b1;
        stb.latchDest = 1'b1;
        stb.driveOwn = 1'b1;
        stb.setBsy = 1'b1;
        stb.loadTimer = 1'b1;
        stb.timerSel = TM_ARB;
        nxt = ST_ARB;
      end
      ST_ARB: if (timerDone) begin
        if (arbWon) begin
          stb.setSel = 1'b1;
          stb.loadTimer = 1'b1;
          stb.timerSel = TM_SETTLE;
          nxt = ST_SETTLE;
        end else begin
          stb.releaseAll = 1'b1;
          setLost = 1'b1;
          nxt = ST_IDLE;
        end
      end
      ST_SETTLE: if (timerDone) begin
        stb.driveBoth = 1'b1;
        stb.loadTimer = 1'b1;
        stb.timerSel = TM_DEST;
        nxt = ST_DEST;
      end
      ST_DEST: if (timerDone) begin
        stb.clrBsy = 1'b1;
        stb.setAtn = 1'b1;
        stb.atnVal = atnQ;
        stb.loadTimer = 1'b1;
        stb.timerSel = TM_RELEASE;
        nxt = ST_RELBSY;
      end
      ST_RELBSY: if (timerDone) begin
        if (bsyIn) goDeskew = 1'b1;
        else begin
          stb.loadTimer = 1'b1;
          stb.timerSel = TM_SELTO;
          nxt = ST_SELWAIT;
        end
      end
      ST_SELWAIT: begin
        if (bsyIn) goDeskew = 1'b1;
        else if (timerDone) begin
          stb.releaseData = 1'b1;
          stb.loadTimer = 1'b1;
          stb.timerSel = TM_ABORT;
          nxt = ST_ABORT;
        end
      end
      ST_ABORT: if (timerDone) begin
        if (bsyIn) goDeskew = 1'b1;
        else begin
          stb.releaseAll = 1'b1;
          setDisc = 1'b1;
          nxt = ST_IDLE;
        end
      end
      ST_DESKEW: if (timerDone) begin
        stb.releaseData = 1'b1;
        stb.clrSel = 1'b1;
        enterTgt = reselQ;
        enterInit = !reselQ;
        nxt = ST_CONN;
      end
      ST_CONN: if (initMode && !bsyIn) begin
        stb.releaseAll = 1'b1;
        setDisc = 1'b1;
        dropMode = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase

    if (goDeskew) begin
      stb.loadTimer = 1'b1;
      stb.timerSel = TM_DESKEW;
      stb.setBsy = reselQ;
      nxt = ST_DESKEW;
    end

    if (softRst) begin
      stb = '0;
      stb.timerSel = TM_DEST;
      stb.releaseAll = 1'b1;
      {latchCmd, setDisc, setLost, enterInit, enterTgt} = '0;
      dropMode = 1'b1;
      clrFlags = 1'b1;
      nxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      reselQ <= 1'b0;
      atnQ <= 1'b0;
      initMode <= 1'b0;
      targetMode <= 1'b0;
      discIrq <= 1'b0;
      arbLost <= 1'b0;
    end else begin
      state <= nxt;
      if (latchCmd) begin
        reselQ <= (cmdLow == CMD_RESELECT);
        atnQ <= (cmdLow == CMD_SELECT_ATN) || (cmdLow == CMD_SELECT_ATN_STOP);
      end
      if (clrFlags) begin
        discIrq <= 1'b0;
        arbLost <= 1'b0;
      end
      if (setDisc) discIrq <= 1'b1;
      if (setLost) arbLost <= 1'b1;
      if (dropMode) begin
        initMode <= 1'b0;
        targetMode <= 1'b0;
      end
      if (enterInit) initMode <= 1'b1;
      if (enterTgt) targetMode <= 1'b1;
    end
  end

endmodule

// File: rtl/scsiSelSeq.sv
module scsiSelSeq
  import scsiSelPkg::*;
#(
  parameter int ID_W           = 3,
  parameter int TO_W           = 8,
  parameter int ARB_CYCLES     = 24,
  parameter int SETTLE_CYCLES  = 6,
  parameter int RELEASE_CYCLES = 2,
  parameter int ABORT_CYCLES   = 100,
  localparam int BUS_W         = 1 << ID_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             softRst,
  input  logic             startCmd,
  input  logic [7:0]       cmdCode,
  input  logic [ID_W-1:0]  ownId,
  input  logic [ID_W-1:0]  destId,
  input  logic [TO_W-1:0]  selTimeout,
  input  logic [BUS_W-1:0] busDataIn,
  input  logic             bsyIn,
  output logic [BUS_W-1:0] dataOut,
  output logic             dataOe,
  output logic             selOut,
  output logic             bsyOut,
  output logic             atnOut,
  output logic             initMode,
  output logic             targetMode,
  output logic             discIrq,
  output logic             arbLost
);

  ctrlStrobe_t stb;
  logic timerDone;
  logic arbWon;

  scsiSelCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .softRst(softRst), .startCmd(startCmd),
    .cmdCode(cmdCode), .timerDone(timerDone), .arbWon(arbWon), .bsyIn(bsyIn),
    .stb(stb), .initMode(initMode), .targetMode(targetMode),
    .discIrq(discIrq), .arbLost(arbLost)
  );

  scsiSelDatapath #(
    .ID_W(ID_W), .TO_W(TO_W), .ARB_CYCLES(ARB_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES), .RELEASE_CYCLES(RELEASE_CYCLES),
    .ABORT_CYCLES(ABORT_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ownId(ownId), .destId(destId),
    .selTimeout(selTimeout), .busDataIn(busDataIn), .timerDone(timerDone),
    .arbWon(arbWon), .dataOut(dataOut), .dataOe(dataOe), .selOut(selOut),
    .atnOut(atnOut), .bsyOut(bsyOut)
  );

endmodule

// File: rtl/scsiSelSeqChk.sv
module scsiSelSeqChk #(
  parameter int ID_W  = 3,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             softRst,
  input logic [ID_W-1:0]  ownId,
  input logic             bsyIn,
  input logic [BUS_W-1:0] dataOut,
  input logic             dataOe,
  input logic             selOut,
  input logic             bsyOut,
  input logic             atnOut,
  input logic             initMode,
  input logic             targetMode,
  input logic             discIrq,
  input logic             arbLost
);

  AST_LOST_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(arbLost) |-> !selOut && !bsyOut && !atnOut && !dataOe); // R1

  AST_OWN_BIT_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    selOut && dataOe |-> dataOut[ownId]); // R3

  AST_MODES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(initMode && targetMode)); // R5

  AST_MODE_FREES_BUS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initMode) || $rose(targetMode) |-> !selOut && !dataOe); // R5

  AST_DISC_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    $rose(discIrq) |-> !selOut && !bsyOut && !atnOut && !dataOe && !initMode); // R7

  AST_INIT_BSY_LOSS: assert property (@(posedge clk) disable iff (!rstN || softRst)
    initMode && !bsyIn |=> !initMode && discIrq); // R8

  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !selOut && !bsyOut && !atnOut && !dataOe && !initMode && !targetMode && !discIrq && !arbLost); // R10

endmodule

bind scsiSelSeq scsiSelSeqChk #(.ID_W(ID_W), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .ownId(ownId), .bsyIn(bsyIn),
  .dataOut(dataOut), .dataOe(dataOe), .selOut(selOut), .bsyOut(bsyOut),
  .atnOut(atnOut), .initMode(initMode), .targetMode(targetMode),
  .discIrq(discIrq), .arbLost(arbLost)
);

// File: tb/tb_scsiSelSeq.sv
module tb_scsiSelSeq;

  localparam int SETTLE  = 6;
  localparam int RELEASE = 2;
  localparam int ABORT   = 100;
  localparam int UNIT    = 8192;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic softRst = 1'b0;
  logic startCmd = 1'b0;
  logic [7:0] cmdCode = 8'h00;
  logic [2:0] ownId = 3'd0;
  logic [2:0] destId = 3'd1;
  logic [7:0] selTimeout = 8'd1;
  logic [7:0] otherBits = 8'h00;
  logic tgtBsy = 1'b0;
  logic [7:0] dataOut;
  logic dataOe, selOut, bsyOut, atnOut, initMode, targetMode, discIrq, arbLost;
  logic [7:0] busDataIn;
  logic bsyIn;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  assign busDataIn = (dataOe ? dataOut : 8'h00) | (selOut ? 8'h00 : otherBits);
  assign bsyIn = bsyOut | tgtBsy;

  always #4 clk = ~clk;

  scsiSelSeq dut (
    .clk(clk), .rstN(rstN), .softRst(softRst), .startCmd(startCmd),
    .cmdCode(cmdCode), .ownId(ownId), .destId(destId), .selTimeout(selTimeout),
    .busDataIn(busDataIn), .bsyIn(bsyIn), .dataOut(dataOut), .dataOe(dataOe),
    .selOut(selOut), .bsyOut(bsyOut), .atnOut(atnOut), .initMode(initMode),
    .targetMode(targetMode), .discIrq(discIrq), .arbLost(arbLost)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 190000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer than 190000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int winnerOf(input logic [7:0] bits);
    int w = -1;
    for (int i = 0; i < 8; i++) if (bits[i]) w = i;
    return w;
  endfunction

  task automatic doSoftReset();
    @(negedge clk); softRst = 1'b1; tgtBsy = 1'b0;
    @(negedge clk); softRst = 1'b0; otherBits = 8'h00;
    chk(!selOut && !bsyOut && !atnOut && !dataOe && !initMode && !targetMode && !discIrq && !arbLost,
        "R10 soft reset clears", {selOut, bsyOut, atnOut, dataOe, initMode, targetMode, discIrq, arbLost}, 0);
  endtask

  // resp: sample offset after BSY release when the target answers, -1 for never
  task automatic runSel(input logic [7:0] cmd, input int own, input int dest,
                        input logic [7:0] other, input int resp, input int toVal,
                        input bit exactResp);
    int t = 0, tSel = -1, tBoth = -1, tFall = -1, tResp = -1, tDrop = -1;
    bit atnAt = 1'b0;
    bit bsyAtMode = 1'b0;
    logic [6:0] c = cmd[6:0];
    logic [7:0] both = (8'd1 << own) | (8'd1 << dest);
    bit expLose = (winnerOf(other | (8'd1 << own)) != own);
    bit expAtn = (c == 7'h42) || (c == 7'h43);
    bit expTgt = (c == 7'h44);
    ownId = 3'(own); destId = 3'(dest); otherBits = other; selTimeout = 8'(toVal);
    @(negedge clk); startCmd = 1'b1; cmdCode = cmd;
    @(negedge clk); startCmd = 1'b0;
    while (t < 40000) begin
      @(negedge clk); t++;
      if (tSel < 0 && selOut) tSel = t;
      if (tSel >= 0 && tBoth < 0 && dataOut == both) tBoth = t;
      if (tBoth >= 0 && tFall < 0 && !bsyOut) begin tFall = t; atnAt = atnOut; end
      if (tFall >= 0 && tDrop < 0 && !dataOe) tDrop = t;
      if (arbLost || initMode || targetMode || discIrq) break;
      if (resp >= 0 && tFall >= 0 && tResp < 0 && t == tFall + resp) begin
        tgtBsy = 1'b1; tResp = t;
      end
    end
    bsyAtMode = bsyOut;
    if (expLose) begin
      chk(arbLost && !selOut && !bsyOut && !dataOe && !atnOut, "R1 arbitration lost releases", arbLost, 1);
      return;
    end
    chk(!arbLost && tSel >= 0, "R1 own ID wins", arbLost, 0);
    chk(tBoth - tSel == SETTLE, "R2 settle before destination", tBoth - tSel, SETTLE);
    chk(tBoth >= 0, "R3 own|dest on data lines", (tBoth >= 0) ? 1 : 0, 1);
    chk(tFall - tBoth == 4, "R3 destination held 4 cycles", tFall - tBoth, 4);
    chk(atnAt == expAtn, "R4 ATN at BSY release", atnAt, expAtn);
    if (resp < 0) begin
      chk(tDrop == tFall + RELEASE + UNIT * toVal, "R6 selection timeout length", tDrop - tFall, RELEASE + UNIT * toVal);
      chk(discIrq && t == tDrop + ABORT, "R7 disconnect after abort window", t - tDrop, ABORT);
      chk(!selOut && !bsyOut && !dataOe && !initMode, "R7 lines released on disconnect", {selOut, bsyOut, dataOe}, 0);
      return;
    end
    chk(!discIrq && (initMode == !expTgt) && (targetMode == expTgt), "R5 mode per command",
        {initMode, targetMode}, expTgt ? 1 : 2);
    chk(!selOut && !dataOe, "R5 SEL and data released in mode", {selOut, dataOe}, 0);
    if (exactResp) chk(t == tResp + 3, "R5/R6 deskew after BSY", t - tResp, 3);
    if (expTgt) chk(bsyAtMode, "R5 reselect drives own BSY", bsyAtMode, 1);
    else begin
      @(negedge clk); tgtBsy = 1'b0;
      @(negedge clk);
      chk(!initMode && discIrq, "R8 BSY loss ends initiator mode", {initMode, discIrq}, 1);
    end
  endtask

  initial begin
    int unused;
    unused = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!selOut && !bsyOut && !atnOut && !dataOe && !initMode && !targetMode && !discIrq && !arbLost,
        "R10 reset state", {selOut, bsyOut, dataOe}, 0);

    // directed: plain select, exact response inside the wait
    runSel(8'h41, 2, 5, 8'h00, 5, 1, 1'b1);  doSoftReset();
    // R4 R9: ATN select with bit 7 set
    runSel(8'hC2, 6, 0, 8'h05, 3, 1, 1'b1);  doSoftReset();
    runSel(8'h43, 0, 7, 8'h00, 1, 1, 1'b1);  doSoftReset();
    // R5 reselect into target mode
    runSel(8'h44, 4, 1, 8'h00, 7, 1, 1'b1);  doSoftReset();
    // R1 lose to a higher ID
    runSel(8'h41, 3, 1, 8'h80, 4, 1, 1'b1);  doSoftReset();
    // R6 R7 timeout to disconnect
    runSel(8'h41, 1, 2, 8'h00, -1, 1, 1'b0);  doSoftReset();
    // R7 rescue during abort window
    runSel(8'h42, 5, 2, 8'h00, RELEASE + UNIT + 40, 1, 1'b0);  doSoftReset();
    // R6 late BSY near end of a 2-unit wait
    runSel(8'h41, 7, 3, 8'h00, 16000, 2, 1'b1);  doSoftReset();

    // R9: unknown code is ignored
    @(negedge clk); startCmd = 1'b1; cmdCode = 8'h15;
    @(negedge clk); startCmd = 1'b0;
    repeat (40) @(negedge clk);
    chk(!selOut && !bsyOut && !dataOe && !atnOut && !arbLost, "R9 unknown code drives nothing",
        {selOut, bsyOut, dataOe}, 0);

    // R10 soft reset mid-selection
    ownId = 3'd3; destId = 3'd6;
    @(negedge clk); startCmd = 1'b1; cmdCode = 8'h42;
    @(negedge clk); startCmd = 1'b0;
    repeat (35) @(negedge clk);
    chk(selOut, "R2 SEL asserted before soft reset", selOut, 1);
    doSoftReset();

    // constrained random scenarios
    for (int n = 0; n < 40; n++) begin
      int own = $urandom % 8;
      int dest = (own + 1 + ($urandom % 7)) % 8;
      logic [7:0] oth = ($urandom % 3 == 0) ? 8'h00 : (8'($urandom) & ~(8'd1 << own));
      logic [7:0] cmd = 8'h41 + 8'($urandom % 4);
      if ($urandom % 2 == 1) cmd = cmd | 8'h80;
      runSel(cmd, own, dest, oth, 1 + ($urandom % 40), 1, 1'b1);
      doSoftReset();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule